// File: doc/BRIEF.md
# Parallel-Serial FIR Filter Engine

This block is a 256-tap finite impulse response filter for 18-bit signed samples. Its datapath is parallel-serial. The taps are split into 16 lanes. In each clock cycle every lane multiplies one delayed sample by one coefficient. The 16 products and the running sum are added into a wide accumulator. One filtered output is therefore ready every 16 cycles after a sample is accepted.

A sample arrives with a one-cycle valid strobe. Accepting it shifts it into a 256-stage delay line, which has no reset, and starts a 16-step run. Each lane has its own constant coefficient ROM. The ROM holds four coefficient sets, and a 2-bit select chooses the set. The select is captured together with the sample. When the run completes, the full-precision result appears on a 44-bit signed output together with a one-cycle valid pulse. The result is not scaled.

Top module: `fir_ps_engine`

## Requirements
- R1: While reset is held and right after it is released, out_valid is low and out_data is zero.
- R2: For the m-th accepted sample x[m] with captured select f, out_data equals the sum over t = 0..255 of h_f[t]·x[m−t]. The result is exact in 44-bit two's complement.
- R3: The coefficient value is h_f[t] = ((t·(2f+3) + 7f + 1) mod 509) − 254, where f is the in_fsel value 0..3. Lane k holds taps 16k..16k+15, and set f sits at ROM addresses 16f..16f+15.
- R4: out_valid is high for exactly one cycle, on the 16th rising edge after the edge that accepted the sample.
- R5: An in_valid that arrives while a run is busy, outside its final step, is ignored. That sample never enters the delay line.
- R6: A sample presented during the final step of a run is accepted, so samples spaced exactly 16 cycles apart are all processed.
- R7: in_fsel is sampled only when a sample is accepted. Changing it during a run has no effect on that run's result.
- R8: out_data keeps its value between valid pulses.
- R9: Full-scale samples (−131072 repeated over the whole window) give exact results with no overflow of the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of control and output |
| in_valid | input | 1 | One-cycle strobe that offers a new sample |
| in_data | input | 18 | Signed input sample |
| in_fsel | input | 2 | Coefficient set select, captured with the sample |
| out_valid | output | 1 | One-cycle pulse marking a finished output |
| out_data | output | 44 | Signed full-precision filter output |

## Verification
Random samples at random spacing, with random set selects, check the general convolution. An impulse that follows a zero-filled window reads every coefficient of every set back through the output, which separates coefficient errors from delay-line errors. Runs of full-scale negative samples at the minimum 16-cycle spacing test both accumulator width and back-to-back acceptance. Random runs with stray in_valid pulses and select changes injected mid-run show whether an ignored strobe leaks into the delay line, or a late select change leaks into the coefficients.

// File: rtl/fir_ps_pkg.sv
`timescale 1ns/1ps
package fir_ps_pkg;

   // Constant coefficient generator: set index and tap index to a signed value.
   function automatic int coef_value(int set_idx, int tap);
      int v;
      v = (tap * (2 * set_idx + 3) + 7 * set_idx + 1) % 509;
      return v - 254;
   endfunction

endpackage

// File: rtl/fir_ps_seq.sv
`timescale 1ns/1ps
module fir_ps_seq #(
   parameter int STEPS  = 16,
   parameter int STEP_W = $clog2(STEPS)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              accept_o,
   output logic              busy_o,
   output logic              first_o,
   output logic              last_o,
   output logic [STEP_W-1:0] step_o
);

   logic              busy_q;
   logic [STEP_W-1:0] step_q;

   assign last_o   = busy_q && (step_q == STEP_W'(STEPS - 1));
   assign first_o  = busy_q && (step_q == '0);
   assign accept_o = in_valid && (!busy_q || last_o);
   assign busy_o   = busy_q;
   assign step_o   = step_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         step_q <= '0;
      end else if (accept_o) begin
         busy_q <= 1'b1;
         step_q <= '0;
      end else if (last_o) begin
         busy_q <= 1'b0;
         step_q <= '0;
      end else if (busy_q) begin
         step_q <= step_q + 1'b1;
      end
   end

   // R4 R5
   step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !last_o) |=> (busy_q && step_q == $past(step_q) + 1'b1));

   // R6
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && in_valid) |=> (busy_q && step_q == '0));

endmodule

// File: rtl/fir_ps_delay.sv
`timescale 1ns/1ps
module fir_ps_delay #(
   parameter int DW     = 18,
   parameter int N_TAPS = 256,
   parameter int LANES  = 16,
   parameter int STEP_W = $clog2(N_TAPS / LANES)
)(
   input  logic                clk,
   input  logic                shift_en,
   input  logic [DW-1:0]       din,
   input  logic [STEP_W-1:0]   step,
   output logic [LANES*DW-1:0] taps_o
);

   localparam int LANE_W = $clog2(LANES);

   // Sample line: deliberately without reset.
   logic [DW-1:0] line [N_TAPS];

   always_ff @(posedge clk) begin
      if (shift_en) begin
         line[0] <= din;
         for (int i = 1; i < N_TAPS; i++) line[i] <= line[i-1];
      end
   end

   // Per-lane selector over the lane's own window of delayed samples.
   for (genvar k = 0; k < LANES; k++) begin : g_lane_mux
      if (LANES == 1) begin : g_single
         assign taps_o[k*DW +: DW] = line[step];
      end else begin : g_multi
         assign taps_o[k*DW +: DW] = line[{LANE_W'(k), step}];
      end
   end

endmodule

// File: rtl/fir_ps_coef_rom.sv
`timescale 1ns/1ps
module fir_ps_coef_rom #(
   parameter int CW       = 18,
   parameter int LANE_IDX = 0,
   parameter int STEPS    = 16,
   parameter int SET_W    = 2,
   parameter int STEP_W   = $clog2(STEPS)
)(
   input  logic [SET_W-1:0]     sel,
   input  logic [STEP_W-1:0]    step,
   output logic signed [CW-1:0] coef
);

   localparam int DEPTH = STEPS * (1 << SET_W);

   logic signed [CW-1:0] rom [DEPTH];

   for (genvar a = 0; a < DEPTH; a++) begin : g_fill
      assign rom[a] = CW'(fir_ps_pkg::coef_value(a / STEPS, LANE_IDX * STEPS + a % STEPS));
   end

   assign coef = rom[{sel, step}];

endmodule

// File: rtl/fir_ps_engine.sv
`timescale 1ns/1ps
module fir_ps_engine #(
   parameter int DW     = 18,
   parameter int CW     = 18,
   parameter int N_TAPS = 256,
   parameter int LANES  = 16,
   parameter int SET_W  = 2,
   parameter int ACC_W  = DW + CW + $clog2(N_TAPS)
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic signed [DW-1:0]    in_data,
   input  logic [SET_W-1:0]        in_fsel,
   output logic                    out_valid,
   output logic signed [ACC_W-1:0] out_data
);

   localparam int STEPS  = N_TAPS / LANES;
   localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam int PW     = DW + CW;

   initial begin
      tap_split_chk: assert (N_TAPS % LANES == 0 && STEPS >= 2)
         else $error("N_TAPS must be a multiple of LANES with at least two steps");
      pow2_chk: assert ((1 << $clog2(STEPS)) == STEPS && (1 << $clog2(LANES)) == LANES)
         else $error("STEPS and LANES must be powers of two");
      acc_width_chk: assert (ACC_W >= DW + CW + $clog2(N_TAPS))
         else $error("ACC_W too narrow for full bit growth");
   end

   logic                    accept, busy, first, last;
   logic [STEP_W-1:0]       step;
   logic [SET_W-1:0]        fsel_q;
   logic [LANES*DW-1:0]     taps;
   logic signed [PW-1:0]    prod [LANES];
   logic signed [ACC_W-1:0] psum, acc_next, acc_q;

   fir_ps_seq #(.STEPS(STEPS), .STEP_W(STEP_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .accept_o (accept),
      .busy_o   (busy),
      .first_o  (first),
      .last_o   (last),
      .step_o   (step)
   );

   fir_ps_delay #(.DW(DW), .N_TAPS(N_TAPS), .LANES(LANES), .STEP_W(STEP_W)) u_line (
      .clk      (clk),
      .shift_en (accept),
      .din      (in_data),
      .step     (step),
      .taps_o   (taps)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      fsel_q <= '0;
      else if (accept) fsel_q <= in_fsel;
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic signed [CW-1:0] coef_k;
      fir_ps_coef_rom #(.CW(CW), .LANE_IDX(k), .STEPS(STEPS), .SET_W(SET_W), .STEP_W(STEP_W)) u_rom (
         .sel  (fsel_q),
         .step (step),
         .coef (coef_k)
      );
      assign prod[k] = $signed(taps[k*DW +: DW]) * coef_k;
   end

   // K-input product sum plus the running total: the (K+1)-input adder.
   always_comb begin
      psum = '0;
      for (int k = 0; k < LANES; k++) psum = psum + ACC_W'(prod[k]);
   end

   assign acc_next = (first ? '0 : acc_q) + psum;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q     <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         if (busy) acc_q <= acc_next;
         out_valid <= last;
         if (last) out_data <= acc_next;
      end
   end

   // R4
   pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R8
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !last |=> $stable(out_data));

   // R7
   fsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> $stable(fsel_q));

   // R4
   pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> !out_valid);

endmodule

// File: tb/sim_fir_ps_engine.sv
`timescale 1ns/1ps
module sim_fir_ps_engine;

   localparam int N = 256;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic signed [17:0] in_data = '0;
   logic [1:0]         in_fsel = '0;
   logic               out_valid;
   logic signed [43:0] out_data;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   int last_acc = -1000;
   bit started = 1'b0;
   bit hold_bad = 1'b0;
   longint held = 0;

   int     hist_x[$];
   int     due_q[$];
   longint exp_q[$];
   bit     chk_q[$];
   string  tag_q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc++;

   fir_ps_engine u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_fsel(in_fsel), .out_valid(out_valid), .out_data(out_data)
   );

   function automatic int coef(int f, int t);
      return ((t * (2 * f + 3) + 7 * f + 1) % 509) - 254;
   endfunction

   function automatic longint exp_y(int f);
      longint s = 0;
      int n = hist_x.size();
      for (int t = 0; t < N; t++)
         s += longint'(coef(f, t)) * longint'(hist_x[n - 1 - t]);
      return s;
   endfunction

   function automatic int rnd_sample();
      return int'($urandom_range(0, 262143)) - 131072;
   endfunction

   task automatic try_accept(int x, int f, int c, string tag);
      if (c - last_acc >= 16) begin
         last_acc = c;
         hist_x.push_back(x);
         due_q.push_back(c + 16);
         chk_q.push_back(hist_x.size() >= N);
         exp_q.push_back(hist_x.size() >= N ? exp_y(f) : 64'sd0);
         tag_q.push_back(tag);
      end
   endtask

   task automatic drive(int x, int f, int gap, int noise_at, string tag);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = x[17:0];
      in_fsel  = f[1:0];
      try_accept(x, f, cyc + 1, tag);
      for (int g = 1; g < gap; g++) begin
         @(negedge clk);
         in_valid = (g == noise_at);
         if (g == noise_at) begin
            int junk = rnd_sample();
            in_data = junk[17:0];
            in_fsel = ~f[1:0];
            try_accept(junk, (~f) & 3, cyc + 1, "R5");
         end
      end
   endtask

   // Output monitor: timing (R4), data (tag), hold between pulses (R8)
   always @(negedge clk) begin
      if (started) begin
         if (out_valid) begin
            tests++;
            if (due_q.size() == 0 || due_q[0] != cyc) begin
               fails++;
               $display("FAIL R4: pulse at cycle %0d, expected cycle %0d",
                        cyc, due_q.size() ? due_q[0] : -1);
            end else begin
               if (chk_q[0]) begin
                  tests++;
                  if (longint'(out_data) != exp_q[0]) begin
                     fails++;
                     $display("FAIL %s: out_data=%0d expected %0d", tag_q[0],
                              longint'(out_data), exp_q[0]);
                  end
               end
               void'(due_q.pop_front()); void'(exp_q.pop_front());
               void'(chk_q.pop_front()); void'(tag_q.pop_front());
            end
            tests++;
            if (hold_bad) begin
               fails++;
               $display("FAIL R8: out_data moved between pulses, actual changed expected held %0d", held);
            end
            hold_bad = 1'b0;
            held = longint'(out_data);
         end else begin
            if (longint'(out_data) != held) hold_bad = 1'b1;
            if (due_q.size() > 0 && due_q[0] == cyc) begin
               tests++; fails++;
               $display("FAIL R4: no pulse at cycle %0d, actual out_valid=0 expected 1", cyc);
               void'(due_q.pop_front()); void'(exp_q.pop_front());
               void'(chk_q.pop_front()); void'(tag_q.pop_front());
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      // R1: reset state
      tests++;
      if (out_valid !== 1'b0) begin
         fails++; $display("FAIL R1: out_valid=%0b expected 0 in reset", out_valid);
      end
      rst_n = 1'b1;
      @(negedge clk);
      tests++;
      if (out_valid !== 1'b0 || out_data !== '0) begin
         fails++; $display("FAIL R1: out_valid=%0b out_data=%0d expected 0 0", out_valid, out_data);
      end
      started = 1'b1;

      // R2: random samples, spacing and selects
      for (int i = 0; i < 260; i++)
         drive(rnd_sample(), int'($urandom_range(0, 3)), 16 + int'($urandom_range(0, 4)), 0, "R2");

      // R6, R9: full-scale negative samples back to back
      for (int i = 0; i < N; i++) drive(-131072, i % 4, 16, 0, "R6,R9");
      for (int i = 0; i < 8; i++) drive(131071, 3 - (i % 4), 16, 0, "R9");

      // R3: zero window then impulse reads coefficients of every set
      for (int i = 0; i < N; i++) drive(0, 0, 16, 0, "R3");
      drive(1, 0, 16, 0, "R3");
      for (int i = 1; i < N; i++) drive(0, i % 4, 16, 0, "R3");

      // R5, R7: stray strobes and select changes during runs
      for (int i = 0; i < 120; i++)
         drive(rnd_sample(), int'($urandom_range(0, 3)), 18, int'($urandom_range(2, 15)), "R5,R7");

      @(negedge clk);
      in_valid = 1'b0;
      repeat (40) @(negedge clk);
      tests++;
      if (due_q.size() != 0) begin
         fails++; $display("FAIL R4: %0d outputs missing, expected 0", due_q.size());
      end
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule